// File: doc/BRIEF.md
# Four-Channel Scanline Wavetable Mixer

This block is a wavetable sound generator paced by video timing. It has four voices. Each voice owns a phase accumulator and a frequency word, and it chooses one of four 64-entry waveforms of 6-bit samples held in an internal table. On every horizontal line the block services exactly one voice. It reads that voice's current sample, adds the sample to a running partial sum, and advances that voice's phase. After the fourth voice is added, the completed mix is loaded into the DAC output register. The output therefore refreshes once every four lines.

The frame is 521 lines long, which is not a multiple of four. The four-line grouping would therefore slip by one line each frame and cause an audible click. To prevent this, the block realigns its voice rotation at a fixed line. It picks that line from the remainder of the frame length divided by four. A remainder of 1 realigns on entry to the last visible line. A remainder of 2 realigns on the first blank line. A remainder of 0 needs no action. A remainder of 3 cannot be corrected, so the block raises a warning flag.

A separate LED register captures its input only on a rising vertical-sync edge. Writes arrive through a small register port (frequencies and waveform selects) and a table port (sample contents).

Top module: `scanline_mixer`

## Requirements
- R1: After reset the DAC output, the LED output, every phase, every frequency word and every waveform select are zero. The first line strobe after reset is treated as line 0.
- R2: The serviced voice's sample is the table entry at address {waveform select[1:0], phase[15:10]}. A table write places `tblData` at `tblAddr`. Register address 0 to 3 (`regAddr[2]`=0, `regAddr[1:0]`=voice) loads that voice's 16-bit frequency. Address 4 to 7 loads that voice's waveform select from `regData[1:0]`.
- R3: Each `lineStrobe` services one voice, in the order 0, 1, 2, 3. Servicing voice 0 starts a new sum. When voice 3 is serviced, the DAC register is loaded with the sum of the four samples, visible after that clock edge.
- R4: Once its sample has been read, a serviced voice's phase advances by its frequency word, modulo 2^16. Phases of the other voices do not change.
- R5: The DAC output stays stable on every cycle that does not complete a voice-3 service.
- R6: `dacOut` is the top `DAC_W` bits of the 8-bit sum (the whole sum when `DAC_W`=8, the sum shifted right by 4 when `DAC_W`=4). Four full-scale samples give 252 with no overflow.
- R7: With 521 lines and 480 visible lines, entering line 479 forces the rotation back to voice 0 and drops the partial sum.
- R8: `syncWarn` is 1 only when the frame length modulo 4 equals 3. It is 0 for 521 lines.
- R9: `ledOut` captures `ledIn` only on the clock edge where `vSync` is high and it was low on the previous edge. At all other times `ledOut` holds.
- R10: The line count wraps from 520 to 0 on its own. A `lineStrobe` together with `frameStrobe` makes the entered line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStrobe | input | 1 | One-cycle pulse at the start of each scan line |
| frameStrobe | input | 1 | With lineStrobe, marks the entered line as line 0 |
| vSync | input | 1 | Vertical sync level |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register select: frequency (0-3) or waveform (4-7) |
| regData | input | 16 | Register write data |
| tblWe | input | 1 | Sample table write enable |
| tblAddr | input | 8 | Table address {waveform, index} |
| tblData | input | 6 | Table sample data |
| ledIn | input | 8 | LED pattern to capture |
| dacOut | output | DAC_W | Mixed audio output |
| ledOut | output | 8 | Latched LED pattern |
| syncWarn | output | 1 | Frame length cannot be realigned |

## Verification
The assertions assume that `lineStrobe` is a single-cycle pulse and that `frameStrobe` is asserted only together with it. They also assume that `vSync` is low while reset is held. The stimulus produces every line as one strobe cycle followed by idle cycles, raises `frameStrobe` only inside such a strobe, and changes `vSync` only after reset is released. Register and table writes are issued between lines, so a write never coincides with a voice being serviced.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
  localparam int NUM_CH    = 4;
  localparam int SLOT_W    = $clog2(NUM_CH);
  localparam int IDX_W     = 6;
  localparam int WAVE_W    = 2;
  localparam int NUM_WAVES = 1 << WAVE_W;

  // strobes from control to datapath for the line being entered
  typedef struct packed {
    logic              step;    // a voice is serviced this cycle
    logic              resync;  // rotation forced back to voice 0
    logic              finish;  // the serviced voice is the last one
    logic [SLOT_W-1:0] slot;    // voice serviced this cycle
  } mixStrobe_t;
endpackage

// File: rtl/mixer_ctrl.sv
module mixer_ctrl
  import mixer_pkg::*;
#(
  parameter int FRAME_LINES   = 521,
  parameter int VISIBLE_LINES = 480
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStrobe,
  input  logic              frameStrobe,
  input  logic              vSync,
  output mixStrobe_t        strobe,
  output logic              ledLoad,
  output logic              syncWarn,
  output logic [SLOT_W-1:0] slotReg,
  output logic              vSyncPrev
);
  localparam int LINE_W   = $clog2(FRAME_LINES);
  localparam int LINE_MOD = FRAME_LINES % NUM_CH;
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FRAME_LINES - 1);

  logic [LINE_W-1:0] lineCnt;
  logic [LINE_W-1:0] nextLine;
  logic              resyncHit;
  logic [SLOT_W-1:0] curSlot;

  always_comb begin
    if (frameStrobe || lineCnt == LAST_LINE) nextLine = '0;
    else                                     nextLine = lineCnt + 1'b1;
  end

  // realignment line chosen by the frame length remainder
  generate
    if (LINE_MOD == 1) begin : g_lastVisible
      assign resyncHit = lineStrobe && (nextLine == LINE_W'(VISIBLE_LINES - 1));
      assign syncWarn  = 1'b0;
    end else if (LINE_MOD == 2) begin : g_firstBlank
      assign resyncHit = lineStrobe && (nextLine == LINE_W'(VISIBLE_LINES));
      assign syncWarn  = 1'b0;
    end else if (LINE_MOD == 3) begin : g_noFix
      assign resyncHit = 1'b0;
      assign syncWarn  = 1'b1;
    end else begin : g_aligned
      assign resyncHit = 1'b0;
      assign syncWarn  = 1'b0;
    end
  endgenerate

  assign curSlot = resyncHit ? '0 : slotReg;

  always_comb begin
    strobe.step   = lineStrobe;
    strobe.resync = resyncHit;
    strobe.slot   = curSlot;
    strobe.finish = lineStrobe && (curSlot == SLOT_W'(NUM_CH - 1));
  end

  assign ledLoad = vSync && !vSyncPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt   <= LAST_LINE;
      slotReg   <= '0;
      vSyncPrev <= 1'b0;
    end else begin
      vSyncPrev <= vSync;
      if (lineStrobe) begin
        lineCnt <= nextLine;
        slotReg <= curSlot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mixer_datapath.sv
module mixer_datapath
  import mixer_pkg::*;
#(
  parameter int PHASE_W  = 16,
  parameter int SAMPLE_W = 6,
  parameter int DAC_W    = 8,
  parameter int LED_W    = 8,
  localparam int SUM_W   = SAMPLE_W + SLOT_W,
  localparam int TBL_AW  = WAVE_W + IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  mixStrobe_t          strobe,
  input  logic                regWe,
  input  logic [2:0]          regAddr,
  input  logic [PHASE_W-1:0]  regData,
  input  logic                tblWe,
  input  logic [TBL_AW-1:0]   tblAddr,
  input  logic [SAMPLE_W-1:0] tblData,
  input  logic [LED_W-1:0]    ledIn,
  input  logic                ledLoad,
  output logic [DAC_W-1:0]    dacOut,
  output logic [LED_W-1:0]    ledOut,
  output logic [SUM_W-1:0]    partSum
);
  localparam int TBL_DEPTH = NUM_WAVES << IDX_W;

  logic [SAMPLE_W-1:0]             sampleTbl [TBL_DEPTH];
  logic [NUM_CH-1:0][TBL_AW-1:0]   chIdx;
  logic [SAMPLE_W-1:0]             curSample;
  logic [SUM_W-1:0]                baseSum;
  logic [SUM_W-1:0]                newSum;
  logic [SUM_W-1:0]                dacReg;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [PHASE_W-1:0] freqQ;
      logic [PHASE_W-1:0] phaseQ;
      logic [WAVE_W-1:0]  waveQ;
      logic               selMe;

      assign selMe    = regWe && (regAddr[SLOT_W-1:0] == SLOT_W'(c));
      assign chIdx[c] = {waveQ, phaseQ[PHASE_W-1 -: IDX_W]};

      always_ff @(posedge clk) begin
        if (!rstN) begin
          freqQ  <= '0;
          phaseQ <= '0;
          waveQ  <= '0;
        end else begin
          if (selMe && !regAddr[2]) freqQ <= regData;
          if (selMe &&  regAddr[2]) waveQ <= regData[WAVE_W-1:0];
          if (strobe.step && strobe.slot == SLOT_W'(c))
            phaseQ <= phaseQ + freqQ;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (tblWe) sampleTbl[tblAddr] <= tblData;
  end

  assign curSample = sampleTbl[chIdx[strobe.slot]];
  assign baseSum   = (strobe.slot == '0) ? '0 : partSum;
  assign newSum    = baseSum + SUM_W'(curSample);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      partSum <= '0;
      dacReg  <= '0;
      ledOut  <= '0;
    end else begin
      if (strobe.step)   partSum <= newSum;
      if (strobe.finish) dacReg  <= newSum;
      if (ledLoad)       ledOut  <= ledIn;
    end
  end

  assign dacOut = dacReg[SUM_W-1 -: DAC_W];
endmodule

// File: rtl/scanline_mixer.sv
module scanline_mixer
  import mixer_pkg::*;
#(
  parameter int FRAME_LINES   = 521,
  parameter int VISIBLE_LINES = 480,
  parameter int PHASE_W       = 16,
  parameter int SAMPLE_W      = 6,
  parameter int DAC_W         = 8,
  parameter int LED_W         = 8,
  localparam int SUM_W        = SAMPLE_W + SLOT_W,
  localparam int TBL_AW       = WAVE_W + IDX_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineStrobe,
  input  logic                frameStrobe,
  input  logic                vSync,
  input  logic                regWe,
  input  logic [2:0]          regAddr,
  input  logic [PHASE_W-1:0]  regData,
  input  logic                tblWe,
  input  logic [TBL_AW-1:0]   tblAddr,
  input  logic [SAMPLE_W-1:0] tblData,
  input  logic [LED_W-1:0]    ledIn,
  output logic [DAC_W-1:0]    dacOut,
  output logic [LED_W-1:0]    ledOut,
  output logic                syncWarn
);
  mixStrobe_t        strobe;
  logic              ledLoad;
  logic [SLOT_W-1:0] slotReg;
  logic              vSyncPrev;
  logic [SUM_W-1:0]  partSum;

  mixer_ctrl #(
    .FRAME_LINES  (FRAME_LINES),
    .VISIBLE_LINES(VISIBLE_LINES)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineStrobe (lineStrobe),
    .frameStrobe(frameStrobe),
    .vSync      (vSync),
    .strobe     (strobe),
    .ledLoad    (ledLoad),
    .syncWarn   (syncWarn),
    .slotReg    (slotReg),
    .vSyncPrev  (vSyncPrev)
  );

  mixer_datapath #(
    .PHASE_W (PHASE_W),
    .SAMPLE_W(SAMPLE_W),
    .DAC_W   (DAC_W),
    .LED_W   (LED_W)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .regWe  (regWe),
    .regAddr(regAddr),
    .regData(regData),
    .tblWe  (tblWe),
    .tblAddr(tblAddr),
    .tblData(tblData),
    .ledIn  (ledIn),
    .ledLoad(ledLoad),
    .dacOut (dacOut),
    .ledOut (ledOut),
    .partSum(partSum)
  );
endmodule

// File: rtl/mixer_checker.sv
module mixer_checker
  import mixer_pkg::*;
#(
  parameter int SAMPLE_W = 6,
  parameter int DAC_W    = 8,
  parameter int LED_W    = 8,
  localparam int SUM_W   = SAMPLE_W + SLOT_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              step,
  input logic              resync,
  input logic              finish,
  input logic [SLOT_W-1:0] slotReg,
  input logic [SUM_W-1:0]  partSum,
  input logic [DAC_W-1:0]  dacOut,
  input logic              vSync,
  input logic              vSyncPrev,
  input logic [LED_W-1:0]  ledOut
);
  localparam int MAX_SUM = NUM_CH * ((1 << SAMPLE_W) - 1);

  // R5: DAC holds unless a voice-3 service completes
  assert_dac_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !finish |=> $stable(dacOut));

  // R3: rotation advances by one voice per serviced line
  assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (step && !resync) |=> slotReg == SLOT_W'($past(slotReg) + 1));

  // R3: rotation holds between lines
  assert_slot_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(slotReg));

  // R7: a realigned line services voice 0, so voice 1 follows
  assert_resync_R7: assert property (@(posedge clk) disable iff (!rstN)
    (step && resync) |=> slotReg == SLOT_W'(1));

  // R6: the running sum never exceeds four full-scale samples
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    partSum <= SUM_W'(MAX_SUM));

  // R9: LED holds unless vSync has just risen
  assert_led_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(vSync && !vSyncPrev) |=> $stable(ledOut));
endmodule

bind scanline_mixer mixer_checker #(
  .SAMPLE_W(SAMPLE_W),
  .DAC_W   (DAC_W),
  .LED_W   (LED_W)
) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .step     (strobe.step),
  .resync   (strobe.resync),
  .finish   (strobe.finish),
  .slotReg  (slotReg),
  .partSum  (partSum),
  .dacOut   (dacOut),
  .vSync    (vSync),
  .vSyncPrev(vSyncPrev),
  .ledOut   (ledOut)
);

// File: tb/test_scanline_mixer.sv
module test_scanline_mixer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStrobe = 1'b0;
  logic       frameStrobe = 1'b0;
  logic       vSync = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [15:0] regData = '0;
  logic       tblWe = 1'b0;
  logic [7:0] tblAddr = '0;
  logic [5:0] tblData = '0;
  logic [7:0] ledIn = '0;
  logic [7:0] dacOut;
  logic [3:0] dacNarrow;
  logic [7:0] ledOut;
  logic [7:0] ledNarrow;
  logic       syncWarn;
  logic       warnNarrow;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // bench model state
  logic [15:0] mFreq [4];
  logic [15:0] mPhase [4];
  int mWave [4];
  int mTbl [256];
  int mSlot = 0;
  int mPart = 0;
  int mDac = 0;
  int mLine = 520;

  always #2 clk = ~clk;

  scanline_mixer i_scanline_mixer (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .frameStrobe(frameStrobe),
    .vSync(vSync), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData), .ledIn(ledIn),
    .dacOut(dacOut), .ledOut(ledOut), .syncWarn(syncWarn)
  );

  scanline_mixer #(.DAC_W(4)) i_narrow (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .frameStrobe(frameStrobe),
    .vSync(vSync), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData), .ledIn(ledIn),
    .dacOut(dacNarrow), .ledOut(ledNarrow), .syncWarn(warnNarrow)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (line %0d)", tag, act, exp, mLine);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic int tabVal(input int w, input int i);
    return (i * (2 * w + 1) + 5 * w) % 64;
  endfunction

  task automatic writeReg(input int addr, input int data);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'(addr); regData = 16'(data);
    @(negedge clk);
    regWe = 1'b0;
    if (addr < 4) mFreq[addr] = 16'(data);
    else          mWave[addr - 4] = data & 3;
  endtask

  task automatic writeTbl(input int addr, input int data);
    @(negedge clk);
    tblWe = 1'b1; tblAddr = 8'(addr); tblData = 6'(data);
    @(negedge clk);
    tblWe = 1'b0;
    mTbl[addr] = data;
  endtask

  // one scan line: model update, strobe, check at the following negedge
  task automatic runLine(input bit fs, input bit wrapped);
    int ch;
    int s;
    int base;
    string tag;
    mLine = fs ? 0 : ((mLine == 520) ? 0 : mLine + 1);
    if (mLine == 479) mSlot = 0;
    ch = mSlot;
    s = mTbl[mWave[ch] * 64 + int'(mPhase[ch][15:10])];
    base = (mSlot == 0) ? 0 : mPart;
    mPart = base + s;
    mPhase[ch] = mPhase[ch] + mFreq[ch];
    if (mSlot == 3) begin
      mDac = mPart;
      if (mLine >= 479 && mLine <= 482) tag = "R7 realigned group";
      else if (wrapped && mLine <= 3)   tag = "R10 wrapped frame";
      else                              tag = "R2 R3 R4 mix";
    end else begin
      tag = "R5 hold";
    end
    lineStrobe = 1'b1; frameStrobe = fs;
    @(negedge clk);
    lineStrobe = 1'b0; frameStrobe = 1'b0;
    check(dacOut == 8'(mDac), tag, int'(dacOut), mDac);
    check(dacNarrow == 4'(mDac >> 4), {"R6 narrow ", tag}, int'(dacNarrow), mDac >> 4);
    mSlot = (mSlot + 1) % 4;
    @(negedge clk);
  endtask

  task automatic testReset();
    check(dacOut == 0, "R1 dac reset", int'(dacOut), 0);
    check(ledOut == 0, "R1 led reset", int'(ledOut), 0);
    check(syncWarn == 1'b0, "R8 warn flag", int'(syncWarn), 0);
    check(warnNarrow == 1'b0, "R8 warn flag narrow", int'(warnNarrow), 0);
  endtask

  task automatic testConfig();
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 64; i++)
        writeTbl(w * 64 + i, tabVal(w, i));
    writeReg(0, 16'h0400);
    writeReg(1, 16'h0800);
    writeReg(2, 16'h0C40);
    writeReg(3, 16'hFC00);
    writeReg(4, 0);
    writeReg(5, 1);
    writeReg(6, 2);
    writeReg(7, 3);
  endtask

  // two frames: first starts with frameStrobe, second wraps by itself
  task automatic testFrames();
    for (int l = 0; l < 521; l++) runLine(l == 0, 1'b0);
    for (int l = 0; l < 521; l++) runLine(1'b0, 1'b1);
  endtask

  task automatic testFullScale();
    for (int i = 0; i < 64; i++) writeTbl(3 * 64 + i, 63);
    for (int c = 0; c < 4; c++) writeReg(4 + c, 3);
    runLine(1'b1, 1'b0);
    for (int l = 0; l < 8; l++) runLine(1'b0, 1'b0);
    check(dacOut == 8'd252, "R6 full scale", int'(dacOut), 252);
    check(dacNarrow == 4'd15, "R6 full scale narrow", int'(dacNarrow), 15);
  endtask

  task automatic testLed();
    @(negedge clk);
    ledIn = 8'hA5;
    repeat (3) @(negedge clk);
    check(ledOut == 8'h00, "R9 no edge", int'(ledOut), 0);
    vSync = 1'b1;
    @(negedge clk);
    check(ledOut == 8'hA5, "R9 rising edge", int'(ledOut), 'hA5);
    ledIn = 8'h3C;
    repeat (3) @(negedge clk);
    check(ledOut == 8'hA5, "R9 held high", int'(ledOut), 'hA5);
    vSync = 1'b0;
    repeat (2) @(negedge clk);
    check(ledOut == 8'hA5, "R9 falling edge", int'(ledOut), 'hA5);
    vSync = 1'b1;
    @(negedge clk);
    check(ledOut == 8'h3C, "R9 second edge", int'(ledOut), 'h3C);
    vSync = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 4; c++) begin
      mFreq[c] = '0; mPhase[c] = '0; mWave[c] = 0;
    end
    for (int i = 0; i < 256; i++) mTbl[i] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testFrames();
    testFullScale();
    testLed();
    done = 1;
    report();
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
        report();
      end
    end
  end
endmodule